// File: doc/BRIEF.md
# Per-Access Policy Data Cache

This block is a small direct-mapped data cache that sits between a processor load/store port and a slower word-wide memory port. Each core request carries a two-bit attribute that picks how the access is treated: cacheable with write-back, cacheable with write-through, or uncached. The cache keeps a tag, a valid bit and a dirty bit per line. It sequences dirty-line write-backs and line fills on the memory side. Write-through and uncached stores go to memory through a short posted-write FIFO.

The core side uses a valid/ready handshake. The core holds a request stable until `req_ready_o` is high. For a load, the data on `req_rdata_o` is valid in that same cycle. The memory side uses one word per valid/ready beat. A beat with `mem_we_o` high is a store. A beat with it low is a read, and its data on `mem_rdata_i` is taken in the handshake cycle.

The cache has 8 lines of 4 words of 32 bits. A word address splits into word offset (bits 1:0), line index (bits 4:2) and tag (the rest). Any read or write-back of the memory on behalf of a line waits until the posted-write FIFO has drained. An uncached load whose word address matches a posted write stalls until that write has reached memory.

Top module: `policy_dcache`

## Requirements
- R1: After reset every line is invalid, the write FIFO is empty, and `mem_valid_o` and `req_ready_o` are low while no request is presented.
- R2: A cacheable load (attribute 0 = write-back, 1 = write-through) that hits returns the cached word in the cycle it is accepted, with no memory beat.
- R3: A cacheable load that misses on a clean or invalid line reads the 4 words of its line from memory in offset order 0..3. It installs them, then returns the requested word.
- R4: A write-back store (attribute 0) that hits writes only the cached word and marks the line dirty. No memory write is issued for it.
- R5: A line that is both valid and dirty, when it is replaced, is written to memory as 4 beats in offset order with its cached contents. This happens before the 4 fill reads of the new line, and `req_ready_o` stays low throughout.
- R6: A write-back store that misses fills the line from memory, then merges the store into it. The other words keep their memory values.
- R7: A write-through store (attribute 1) that hits updates both the cached word and memory.
- R8: A write-through store that misses writes memory only. It does not allocate, so a later cacheable load to that line still fills from memory.
- R9: An uncached access (attribute bit 1 set, i.e. 2 or 3) never fills or writes the cache. An uncached load is a single memory read of its own word address.
- R10: An uncached load to a word with a posted store pending returns the stored value, never the old memory word.
- R11: The write FIFO holds 4 stores and drains them to memory in acceptance order. A write-through or uncached store presented while it is full is held (ready low) until an entry drains.
- R12: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request present |
| req_ready_o | output | 1 | Core request completes this cycle |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_attr_i | input | 2 | 0 write-back, 1 write-through, 2/3 uncached |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 32 | Store data |
| req_rdata_o | output | 32 | Load data, valid with req_ready_o |
| mem_valid_o | output | 1 | Memory beat requested |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Write beat data |
| mem_rdata_i | input | 32 | Read beat data, valid in the handshake cycle |

## Verification
The bench logs every memory beat in order. Its checks target these corner cases:

- Eviction ordering. A controller that fetched before writing back, or that wrote back stale words, would show read beats ahead of write beats or lose the merged store value.
- Write-through miss allocation. A cache that allocated on such a miss would skip the later fill reads the bench expects.
- Read-after-posted-write hazard. With memory made slow, an uncached load to a just-posted word must return the new value. A design without the buffer check would return the old memory word.
- Full FIFO. With memory stalled, a fifth posted store must be held. A design that dropped or reordered it would show the wrong write sequence.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    ATTR_WB = 2'd0,
    ATTR_WT = 2'd1,
    ATTR_NC = 2'd2
  } pdc_attr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_NCRD,
    ST_NCDONE
  } pdc_state_e;
endpackage

// File: rtl/pdc_tags.sv
module pdc_tags #(
  parameter int LINES = 8,
  parameter int TAG_W = 11,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_i,
  input  logic             dirty_i,
  output logic             hit_o,
  output logic             vld_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] vld_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      vld_q[idx_i]   <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= tag_i;
  end

  assign vld_o   = vld_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign hit_o   = vld_o && (tag_o == tag_i);

  // R4
  dirty_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_i |-> hit_o);
  // R3
  fill_no_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> !dirty_o || !$stable(idx_i));
endmodule

// File: rtl/pdc_data.sv
module pdc_data #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ENTRIES = LINES * WORDS;
  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{idx_i, wr_off_i}] <= wdata_i;
  end

  assign rdata_o = mem_q[{idx_i, rd_off_i}];
endmodule

// File: rtl/pdc_wbuf.sv
module pdc_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              match_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, hit_v;
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [PTR_W:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      if (push_i) begin
        wr_q        <= wr_q + PTR_W'(1);
        vld_q[wr_q] <= 1'b1;
      end
      if (pop_i) begin
        rd_q        <= rd_q + PTR_W'(1);
        vld_q[rd_q] <= 1'b0;
      end
      cnt_q <= cnt_q + (PTR_W+1)'(push_i) - (PTR_W+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_q] <= push_addr_i;
      data_q[wr_q] <= push_data_i;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_look
    assign hit_v[i] = vld_q[i] && (addr_q[i] == look_addr_i);
  end

  assign match_o     = |hit_v;
  assign full_o      = (cnt_q == (PTR_W+1)'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_q];
  assign head_data_o = data_q[rd_q];

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/policy_dcache.sv
module policy_dcache
  import pdc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LINES    = 8,
  parameter int WORDS    = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [1:0]        req_attr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  pdc_state_e state_q, state_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] ncd_q;

  logic [TAG_W-1:0] req_tag, line_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off, rd_off, wr_off;
  logic is_nc, is_wt, hit, line_vld, line_dirty, fill_done, set_dirty;
  logic data_we;
  logic [DATA_W-1:0] data_wdata, data_rd;
  logic wb_push, wb_pop, wb_full, wb_empty, wb_match;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic own, c_valid, c_we;
  logic [ADDR_W-1:0] c_addr;

  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign req_off = req_addr_i[OFF_W-1:0];
  assign is_nc   = req_attr_i[1];
  assign is_wt   = (req_attr_i == ATTR_WT);

  pdc_tags #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk_i, .rst_ni, .idx_i(req_idx), .tag_i(req_tag), .fill_i(fill_done),
    .dirty_i(set_dirty), .hit_o(hit), .vld_o(line_vld), .dirty_o(line_dirty),
    .tag_o(line_tag)
  );

  pdc_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W),
             .OFF_W(OFF_W)) u_data (
    .clk_i, .we_i(data_we), .idx_i(req_idx), .wr_off_i(wr_off),
    .wdata_i(data_wdata), .rd_off_i(rd_off), .rdata_o(data_rd)
  );

  pdc_wbuf #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk_i, .rst_ni, .push_i(wb_push), .push_addr_i(req_addr_i),
    .push_data_i(req_wdata_i), .pop_i(wb_pop), .full_o(wb_full),
    .empty_o(wb_empty), .head_addr_o(wb_addr), .head_data_o(wb_data),
    .look_addr_i(req_addr_i), .match_o(wb_match)
  );

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    req_ready_o = 1'b0;
    req_rdata_o = data_rd;
    wb_push     = 1'b0;
    data_we     = 1'b0;
    data_wdata  = req_wdata_i;
    wr_off      = req_off;
    rd_off      = req_off;
    set_dirty   = 1'b0;
    fill_done   = 1'b0;
    c_valid     = 1'b0;
    c_we        = 1'b0;
    c_addr      = req_addr_i;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (is_nc) begin
          if (req_we_i) begin
            if (!wb_full) begin req_ready_o = 1'b1; wb_push = 1'b1; end
          end else if (!wb_match && (wb_empty || mem_ready_i)) begin
            state_d = ST_NCRD;   // bypass only non-matching posted writes
          end
        end else if (hit) begin
          if (!req_we_i) begin
            req_ready_o = 1'b1;
          end else if (is_wt) begin
            if (!wb_full) begin
              req_ready_o = 1'b1; data_we = 1'b1; wb_push = 1'b1;
            end
          end else begin
            req_ready_o = 1'b1; data_we = 1'b1; set_dirty = 1'b1;
          end
        end else if (req_we_i && is_wt) begin
          if (!wb_full) begin req_ready_o = 1'b1; wb_push = 1'b1; end
        end else if (wb_empty) begin
          cnt_d   = '0;
          state_d = (line_vld && line_dirty) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        rd_off  = cnt_q;
        c_valid = 1'b1;
        c_we    = 1'b1;
        c_addr  = {line_tag, req_idx, cnt_q};
        if (mem_ready_i) begin
          cnt_d = cnt_q + OFF_W'(1);
          if (cnt_q == LAST) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        c_valid = 1'b1;
        c_addr  = {req_tag, req_idx, cnt_q};
        if (mem_ready_i) begin
          data_we    = 1'b1;
          wr_off     = cnt_q;
          data_wdata = mem_rdata_i;
          cnt_d      = cnt_q + OFF_W'(1);
          if (cnt_q == LAST) begin
            fill_done = 1'b1;
            state_d   = ST_IDLE;   // request re-evaluates as a hit
          end
        end
      end
      ST_NCRD: begin
        c_valid = 1'b1;
        if (mem_ready_i) state_d = ST_NCDONE;
      end
      ST_NCDONE: begin
        req_ready_o = 1'b1;
        req_rdata_o = ncd_q;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ncd_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_NCRD && mem_ready_i) ncd_q <= mem_rdata_i;
    end
  end

  assign own         = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_NCRD);
  assign mem_valid_o = own ? c_valid : !wb_empty;
  assign mem_we_o    = own ? c_we : 1'b1;
  assign mem_addr_o  = own ? c_addr : wb_addr;
  assign mem_wdata_o = own ? data_rd : wb_data;
  assign wb_pop      = !own && !wb_empty && mem_ready_i;

  // R12
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));
  // R2
  load_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_we_i && !is_nc && state_q == ST_IDLE |-> hit);
  // R5
  seq_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own |-> !req_ready_o);
  // R5
  evict_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EVICT |-> line_vld && line_dirty);
  // R9
  nc_no_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FILL |-> !is_nc);
  // R4
  wb_store_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_dirty |-> !wb_push);
endmodule

// File: tb/policy_dcache_bench.sv
`timescale 1ns/1ps
module policy_dcache_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]  req_attr = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        mem_valid, mem_we, mem_rdy;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  policy_dcache u_policy_dcache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_attr_i(req_attr), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_rdata_o(req_rdata), .mem_valid_o(mem_valid), .mem_ready_i(mem_rdy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // memory model with beat log
  logic [31:0] bmem [4096];
  logic        log_we  [256];
  logic [15:0] log_adr [256];
  logic [31:0] log_dat [256];
  int log_n;
  int mem_mode = 0;  // 0 always ready, 1 ready every third cycle, 2 never
  int rcnt = 0;

  assign mem_rdata = bmem[mem_addr[11:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) bmem[i] <= 32'hA000_0000 | i;
      log_n <= 0;
    end else if (mem_valid && mem_rdy) begin
      if (mem_we) bmem[mem_addr[11:0]] <= mem_wdata;
      log_we[log_n[7:0]]  <= mem_we;
      log_adr[log_n[7:0]] <= mem_addr;
      log_dat[log_n[7:0]] <= mem_we ? mem_wdata : mem_rdata;
      log_n <= log_n + 1;
    end
  end

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    case (mem_mode)
      0: mem_rdy <= 1'b1;
      1: mem_rdy <= (rcnt % 3 == 0);
      default: mem_rdy <= 1'b0;
    endcase
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] attr, input logic [15:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int waited);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_attr = attr; req_addr = a; req_wdata = wd;
    waited = 0;
    #1;
    while (!req_ready && waited < 2000) begin
      @(negedge clk); #1;
      waited++;
    end
    if (waited >= 2000) chk(1'b0, "watchdog", 32'(waited), 0);
    rd = req_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rd;
  int w, b;

  task automatic t_reset;
    @(negedge clk);
    chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    chk(req_ready == 1'b0, "R1 req_ready", 32'(req_ready), 0);
    b = log_n;
    access(1'b0, 2'd0, 16'h0001, 0, rd, w);
    chk(log_n - b == 4, "R1 cold line misses", 32'(log_n - b), 4);
  endtask

  task automatic t_read_fill_hit;
    b = log_n;
    access(1'b0, 2'd0, 16'h0012, 0, rd, w);
    chk(rd == 32'hA000_0012, "R3 fill data", rd, 32'hA000_0012);
    chk(log_n - b == 4, "R3 beat count", 32'(log_n - b), 4);
    for (int i = 0; i < 4; i++)
      chk(!log_we[b+i] && log_adr[b+i] == 16'h0010 + 16'(i), "R3 fill order",
          32'(log_adr[b+i]), 32'h10 + i);
    b = log_n;
    access(1'b0, 2'd1, 16'h0011, 0, rd, w);
    chk(rd == 32'hA000_0011, "R2 hit data", rd, 32'hA000_0011);
    chk(log_n == b, "R2 no beat on hit", 32'(log_n - b), 0);
  endtask

  task automatic t_wb_hit;
    b = log_n;
    access(1'b1, 2'd0, 16'h0011, 32'h1111_1111, rd, w);
    idle(20);
    chk(log_n == b, "R4 no memory write", 32'(log_n - b), 0);
    chk(bmem[16'h11] == 32'hA000_0011, "R4 memory unchanged", bmem[16'h11], 32'hA000_0011);
    access(1'b0, 2'd0, 16'h0011, 0, rd, w);
    chk(rd == 32'h1111_1111, "R4 cached value", rd, 32'h1111_1111);
  endtask

  task automatic t_evict;
    logic [31:0] ev [4];
    ev[0] = 32'hA000_0010; ev[1] = 32'h1111_1111; ev[2] = 32'hA000_0012; ev[3] = 32'hA000_0013;
    b = log_n;
    access(1'b0, 2'd0, 16'h0090, 0, rd, w);
    chk(rd == 32'hA000_0090, "R5 new line data", rd, 32'hA000_0090);
    chk(log_n - b == 8, "R5 beat count", 32'(log_n - b), 8);
    for (int i = 0; i < 4; i++) begin
      chk(log_we[b+i] && log_adr[b+i] == 16'h0010 + 16'(i), "R5 writeback order",
          32'(log_adr[b+i]), 32'h10 + i);
      chk(log_dat[b+i] == ev[i], "R5 writeback data", log_dat[b+i], ev[i]);
      chk(!log_we[b+4+i] && log_adr[b+4+i] == 16'h0090 + 16'(i), "R5 fill after writeback",
          32'(log_adr[b+4+i]), 32'h90 + i);
    end
  endtask

  task automatic t_wb_alloc;
    b = log_n;
    access(1'b1, 2'd0, 16'h0045, 32'h0000_0055, rd, w);
    chk(log_n - b == 4 && !log_we[b] && log_adr[b] == 16'h0044, "R6 allocate fill",
        32'(log_n - b), 4);
    access(1'b0, 2'd0, 16'h0045, 0, rd, w);
    chk(rd == 32'h55, "R6 merged word", rd, 32'h55);
    access(1'b0, 2'd0, 16'h0046, 0, rd, w);
    chk(rd == 32'hA000_0046, "R6 neighbour word", rd, 32'hA000_0046);
    chk(bmem[16'h45] == 32'hA000_0045, "R6 memory untouched", bmem[16'h45], 32'hA000_0045);
  endtask

  task automatic t_wt;
    access(1'b1, 2'd1, 16'h0091, 32'h77, rd, w);
    idle(20);
    chk(bmem[16'h91] == 32'h77, "R7 memory updated", bmem[16'h91], 32'h77);
    b = log_n;
    access(1'b0, 2'd0, 16'h0091, 0, rd, w);
    chk(rd == 32'h77 && log_n == b, "R7 cache updated", rd, 32'h77);
    b = log_n;
    access(1'b1, 2'd1, 16'h0200, 32'h88, rd, w);
    idle(20);
    chk(log_n - b == 1 && log_we[b] && log_adr[b] == 16'h0200, "R8 single write",
        32'(log_n - b), 1);
    b = log_n;
    access(1'b0, 2'd0, 16'h0200, 0, rd, w);
    chk(log_n - b == 4, "R8 no allocate", 32'(log_n - b), 4);
    chk(rd == 32'h88, "R8 fill sees write", rd, 32'h88);
  endtask

  task automatic t_nc_hazard;
    mem_mode = 1;
    idle(3);
    b = log_n;
    access(1'b1, 2'd2, 16'h0300, 32'h99, rd, w);
    access(1'b0, 2'd3, 16'h0300, 0, rd, w);
    chk(rd == 32'h99, "R10 hazard value", rd, 32'h99);
    chk(log_n - b == 2 && log_we[b] && !log_we[b+1], "R9 single read after write",
        32'(log_n - b), 2);
    mem_mode = 0;
    idle(3);
    b = log_n;
    access(1'b0, 2'd0, 16'h0300, 0, rd, w);
    chk(log_n - b == 4, "R9 no cache fill by uncached", 32'(log_n - b), 4);
  endtask

  task automatic t_full;
    logic [15:0] a0;
    mem_mode = 2;
    idle(3);
    b = log_n;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 2'd2, 16'h0310 + 16'(i), 32'hB0 + i, rd, w);
      chk(w == 0, "R11 accept when not full", 32'(w), 0);
    end
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_attr = 2'd2; req_addr = 16'h0314; req_wdata = 32'hB4;
    #1; a0 = mem_addr;
    for (int i = 0; i < 6; i++) begin
      chk(!req_ready, "R11 full stall", 32'(req_ready), 0);
      @(negedge clk); #1;
    end
    chk(mem_valid && mem_addr == a0 && a0 == 16'h0310, "R12 beat held", 32'(mem_addr), 32'h310);
    mem_mode = 0;
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); #1; w++; end
    chk(req_ready, "R11 accept after drain", 32'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    idle(20);
    chk(log_n - b == 5, "R11 write count", 32'(log_n - b), 5);
    for (int i = 0; i < 5; i++)
      chk(log_we[b+i] && log_adr[b+i] == 16'h0310 + 16'(i) && log_dat[b+i] == 32'hB0 + i,
          "R11 drain order", 32'(log_adr[b+i]), 32'h310 + i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_fill_hit();
    t_wb_hit();
    t_evict();
    t_wb_alloc();
    t_wt();
    t_nc_hazard();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule